// File: doc/BRIEF.md
# Receive Delay Tap Calibration Controller

This block calibrates the receive sampling point of a source-synchronous interface. It drives a delay line built from two cascaded stages of 32 taps each through every tap setting in turn. For each setting it waits a fixed settle time and asks an external transfer engine to run one tuning transfer. The engine answers with a single pass or fail bit, and the block stores that bit in a 64-bit result map at the position of the tap.

Once the sweep is over, the block walks the map one bit per clock. It finds the longest unbroken run of passing taps and picks a tap inside that run. If the run begins at tap zero, the pick leans toward the low end of the run. Otherwise the pick is the middle of the run. The chosen tap, the run length and an error flag are reported together with a one-cycle done pulse. The chosen tap is then written back to the delay stages and held there.

A mode input chooses a half sweep of 32 taps, which uses the first stage only, or a full sweep of 64 taps, which also enables the second stage. The mode is sampled when a sweep starts.

Top module: `rx_tap_calib`

## Requirements
- R1: When a sweep starts, the mode is latched. A sweep issues exactly 32 transfer requests when the latched mode is 0 and exactly 64 when it is 1. Request k applies tap k, and the pass bit returned for request k becomes bit k of the result map. No request is issued after the last one until the next start.
- R2: A tap value t below 32 drives stage one to t and stage two to 0. A tap value of 32 or more drives stage one to 31 and stage two to t-32.
- R3: The second-stage enable output is 0 after reset. It equals the latched mode, so it is high only while a full sweep, or the result of a full sweep, is applied.
- R4: A request stays high, with the tap unchanged, until the engine acknowledges it. Exactly SETTLE_CYCLES clock cycles with the request low come after each start or acknowledge, before the next request rises.
- R5: The search finds the longest run of consecutive ones in the map, scanning from bit 0 upward. A later run replaces the stored best run only when it is strictly longer, so among equal runs the lowest one wins. The reported length is the length of that run.
- R6: Early exit. When bits 63..32 of the map are all zero, the search stops as soon as a run of 12 or more has been measured and the best run starts below tap 4. If any bit in 63..32 is set, early exit is disabled and the whole map is searched.
- R7: The chosen tap is len/3 when the best run starts at tap 0. Otherwise it is start + len/2. Both use integer division, and the result is taken modulo 64.
- R8: An all-zero map sets the error flag and reports tap 0 and length 0. Any other map clears the error flag.
- R9: The done output is high for exactly one cycle per sweep, and the results are valid while it is high. From the cycle after done, the stage outputs carry the chosen tap, split as in R2. They hold that value until the next start.
- R10: A start pulse that arrives while a sweep or a search is running is ignored.
- R11: After reset, all of the following are 0: request, done, both stage outputs, the enable, the chosen tap, the run length and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse. Accepted only when idle or holding a result |
| full_mode_i | input | 1 | 1 selects the 64-tap sweep, 0 selects the 32-tap sweep. Sampled at start |
| xfer_req_o | output | 1 | Request to the transfer engine to run one tuning transfer |
| xfer_ack_i | input | 1 | Transfer engine acknowledge, one cycle long |
| xfer_pass_i | input | 1 | Transfer result, valid with the acknowledge. 1 means pass |
| stage1_dly_o | output | 5 | First delay stage setting |
| stage2_dly_o | output | 5 | Second delay stage setting |
| stage2_en_o | output | 1 | Second delay stage enable |
| done_o | output | 1 | One-cycle pulse when the search result is valid |
| best_tap_o | output | 6 | Chosen tap |
| best_len_o | output | 7 | Length of the longest passing run |
| err_o | output | 1 | No tap passed |

## Verification
The hardest case to reach from the ports is the early exit. Whether it fires depends on the whole map: a qualifying run must be found early, a longer run must exist later, and the upper half of the map must be empty. The stimulus therefore returns maps with a 12-tap run at the bottom and a longer run above it. It uses them in half mode, in full mode with an empty upper half, and in full mode with a single pass bit set in the upper half. The first two results must differ from the third. Every result, including those for single-hole and pseudo-random maps, is compared with an independent software walk of the same map. The acknowledge latency changes from step to step so that the settle spacing and the request hold are both exercised.

// File: rtl/rtc_pkg.sv
// Shared types for the receive delay tap calibration controller.
// Assumes nothing beyond IEEE 1800-2017 enums.
package rtc_pkg;

    // Sweep controller phases
    typedef enum logic [2:0] {
        CAL_IDLE,
        CAL_SETTLE,
        CAL_REQ,
        CAL_SEARCH,
        CAL_HOLD
    } cal_state_e;

endpackage

// File: rtl/rtc_tap_split.sv
// Maps a linear tap index onto two cascaded delay stages of 2**TAP_BITS taps.
// Below one stage's range, stage one carries the value. Above it, stage one
// saturates and stage two carries the remainder. Purely combinational.
module rtc_tap_split #(
    parameter int TAP_BITS = 5
) (
    input  logic [TAP_BITS:0]   tap_i,
    output logic [TAP_BITS-1:0] s1_o,
    output logic [TAP_BITS-1:0] s2_o
);
    // Split the index between the stages
    always_comb begin
        if (tap_i[TAP_BITS] == 1'b0) begin
            s1_o = tap_i[TAP_BITS-1:0];
            s2_o = '0;
        end else begin
            s1_o = '1;
            s2_o = tap_i[TAP_BITS-1:0];
        end
    end
endmodule

// File: rtl/rtc_sweep_ctrl.sv
// Steps the delay tap through a half or full sweep. Each tap gets a settle
// wait and then a request to the transfer engine, and the pass bit is stored
// in the map. It then starts the search and holds the result afterwards.
// Assumes the acknowledge is a single-cycle pulse, sent only while the request
// is high.
module rtc_sweep_ctrl
    import rtc_pkg::*;
#(
    parameter int TAP_BITS      = 5,
    parameter int SETTLE_CYCLES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    full_mode_i,
    input  logic                    xfer_ack_i,
    input  logic                    xfer_pass_i,
    input  logic                    search_done_i,
    output logic                    xfer_req_o,
    output logic [TAP_BITS:0]       tap_o,
    output logic                    full_q_o,
    output logic                    hold_o,
    output logic                    search_go_o,
    output logic [(2<<TAP_BITS)-1:0] map_o
);
    localparam int STAGE_TAPS = 1 << TAP_BITS;
    localparam int FULL_TAPS  = 2 * STAGE_TAPS;
    localparam int IDX_W      = TAP_BITS + 1;
    localparam int CNT_W      = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
    localparam logic [IDX_W-1:0] LAST_FULL   = IDX_W'(FULL_TAPS - 1);
    localparam logic [IDX_W-1:0] LAST_HALF   = IDX_W'(STAGE_TAPS - 1);

    cal_state_e            state_q;
    logic [IDX_W-1:0]      tap_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [FULL_TAPS-1:0]  map_q;
    logic                  full_q;
    logic                  go_q;
    logic [IDX_W-1:0]      last_tap;

    // Final tap index for the latched sweep length
    assign last_tap = full_q ? LAST_FULL : LAST_HALF;

    // Sweep sequencing, map capture and search launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAL_IDLE;
            tap_q   <= '0;
            cnt_q   <= '0;
            map_q   <= '0;
            full_q  <= 1'b0;
            go_q    <= 1'b0;
        end else begin
            go_q <= 1'b0;
            case (state_q)
                CAL_IDLE, CAL_HOLD: begin
                    if (start_i) begin
                        state_q <= CAL_SETTLE;
                        tap_q   <= '0;
                        cnt_q   <= '0;
                        map_q   <= '0;
                        full_q  <= full_mode_i;
                    end
                end
                CAL_SETTLE: begin
                    if (cnt_q == SETTLE_LAST) begin
                        state_q <= CAL_REQ;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                CAL_REQ: begin
                    if (xfer_ack_i) begin
                        map_q[tap_q] <= xfer_pass_i;
                        if (tap_q == last_tap) begin
                            state_q <= CAL_SEARCH;
                            go_q    <= 1'b1;
                        end else begin
                            tap_q   <= tap_q + IDX_W'(1);
                            cnt_q   <= '0;
                            state_q <= CAL_SETTLE;
                        end
                    end
                end
                CAL_SEARCH: begin
                    if (search_done_i) begin
                        state_q <= CAL_HOLD;
                    end
                end
                default: state_q <= CAL_IDLE;
            endcase
        end
    end

    assign xfer_req_o  = (state_q == CAL_REQ);
    assign hold_o      = (state_q == CAL_HOLD);
    assign tap_o       = tap_q;
    assign full_q_o    = full_q;
    assign search_go_o = go_q;
    assign map_o       = map_q;

    // R4: an unacknowledged request persists with the tap frozen
    p_req_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req_o && !xfer_ack_i) |=> (xfer_req_o && $stable(tap_q)));

    // R1: a half sweep never reaches the upper stage range
    p_tap_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_q && state_q != CAL_HOLD) |-> (tap_q < IDX_W'(STAGE_TAPS)));
endmodule

// File: rtl/rtc_run_search.sv
// Serial longest-run search over the pass map, one bit per clock. A run is
// judged when it ends; only a strictly longer run replaces the stored best.
// Stops early on a qualifying run when the upper half of the map is empty.
// The result is registered together with a one-cycle done pulse.
// Assumes the map is stable while the search runs.
module rtc_run_search #(
    parameter int TAP_BITS    = 5,
    parameter int EARLY_LEN   = 12,
    parameter int EARLY_START = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     go_i,
    input  logic [(2<<TAP_BITS)-1:0] map_i,
    output logic                     done_o,
    output logic [TAP_BITS:0]        tap_o,
    output logic [TAP_BITS+1:0]      len_o,
    output logic                     err_o
);
    localparam int STAGE_TAPS = 1 << TAP_BITS;
    localparam int FULL_TAPS  = 2 * STAGE_TAPS;
    localparam int IDX_W      = TAP_BITS + 1;
    localparam int LEN_W      = TAP_BITS + 2;
    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(FULL_TAPS - 1);
    localparam logic [IDX_W-1:0] E_START  = IDX_W'(EARLY_START);
    localparam logic [LEN_W-1:0] E_LEN    = LEN_W'(EARLY_LEN);

    logic             active_q;
    logic [IDX_W-1:0] pos_q;
    logic [LEN_W-1:0] cur_len_q;
    logic [IDX_W-1:0] cur_start_q;
    logic [IDX_W-1:0] best_start_q;
    logic [LEN_W-1:0] best_len_q;

    logic             bit_now, upper_zero, run_end, better, early, fin;
    logic [LEN_W-1:0] end_len, nb_len, third, sum;
    logic [IDX_W-1:0] end_start, nb_start, pick;

    // Run bookkeeping for the bit under examination
    always_comb begin
        bit_now    = map_i[pos_q];
        upper_zero = (map_i[FULL_TAPS-1:STAGE_TAPS] == '0);
        run_end    = active_q && ((!bit_now && cur_len_q != '0) ||
                                  (bit_now && pos_q == LAST_POS));
        end_len    = bit_now ? cur_len_q + LEN_W'(1) : cur_len_q;
        end_start  = (cur_len_q == '0) ? pos_q : cur_start_q;
        better     = run_end && (end_len > best_len_q);
        nb_start   = better ? end_start : best_start_q;
        nb_len     = better ? end_len : best_len_q;
        early      = run_end && upper_zero && (end_len >= E_LEN) && (nb_start < E_START);
        fin        = active_q && ((pos_q == LAST_POS) || early);
    end

    // Tap selection inside the best run, biased low for a run at tap 0
    always_comb begin
        third = nb_len / LEN_W'(3);
        sum   = LEN_W'(nb_start) + (nb_len >> 1);
        pick  = (nb_start == '0) ? third[IDX_W-1:0] : sum[IDX_W-1:0];
    end

    // Scan position, run tracking and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q     <= 1'b0;
            pos_q        <= '0;
            cur_len_q    <= '0;
            cur_start_q  <= '0;
            best_start_q <= '0;
            best_len_q   <= '0;
            done_o       <= 1'b0;
            tap_o        <= '0;
            len_o        <= '0;
            err_o        <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (go_i && !active_q) begin
                active_q     <= 1'b1;
                pos_q        <= '0;
                cur_len_q    <= '0;
                cur_start_q  <= '0;
                best_start_q <= '0;
                best_len_q   <= '0;
            end else if (active_q) begin
                best_start_q <= nb_start;
                best_len_q   <= nb_len;
                if (bit_now) begin
                    cur_len_q <= cur_len_q + LEN_W'(1);
                    if (cur_len_q == '0) begin
                        cur_start_q <= pos_q;
                    end
                end else begin
                    cur_len_q <= '0;
                end
                pos_q <= pos_q + IDX_W'(1);
                if (fin) begin
                    active_q <= 1'b0;
                    done_o   <= 1'b1;
                    tap_o    <= pick;
                    len_o    <= nb_len;
                    err_o    <= (nb_len == '0);
                end
            end
        end
    end

    // R9: done never lasts two cycles
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: an error result carries tap 0 and length 0
    p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (tap_o == '0 && len_o == '0));

    // R5: the stored best run never shrinks during a scan
    p_best_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |=> (best_len_q >= $past(best_len_q)));
endmodule

// File: rtl/rx_tap_calib.sv
// Receive delay tap calibration controller, top level.
// Sweeps the two-stage delay, collects pass bits and searches for the best
// tap. It then re-applies that tap through the same stage split.
// Assumes a transfer engine that answers each request with one ack pulse.
module rx_tap_calib #(
    parameter int TAP_BITS      = 5,
    parameter int SETTLE_CYCLES = 3,
    parameter int EARLY_LEN     = 12,
    parameter int EARLY_START   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                full_mode_i,
    output logic                xfer_req_o,
    input  logic                xfer_ack_i,
    input  logic                xfer_pass_i,
    output logic [TAP_BITS-1:0] stage1_dly_o,
    output logic [TAP_BITS-1:0] stage2_dly_o,
    output logic                stage2_en_o,
    output logic                done_o,
    output logic [TAP_BITS:0]   best_tap_o,
    output logic [TAP_BITS+1:0] best_len_o,
    output logic                err_o
);
    localparam int FULL_TAPS = 2 << TAP_BITS;

    logic [TAP_BITS:0]    sweep_tap, apply_tap;
    logic                 full_q, hold, go;
    logic [FULL_TAPS-1:0] map;

    rtc_sweep_ctrl #(
        .TAP_BITS      (TAP_BITS),
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .full_mode_i   (full_mode_i),
        .xfer_ack_i    (xfer_ack_i),
        .xfer_pass_i   (xfer_pass_i),
        .search_done_i (done_o),
        .xfer_req_o    (xfer_req_o),
        .tap_o         (sweep_tap),
        .full_q_o      (full_q),
        .hold_o        (hold),
        .search_go_o   (go),
        .map_o         (map)
    );

    rtc_run_search #(
        .TAP_BITS    (TAP_BITS),
        .EARLY_LEN   (EARLY_LEN),
        .EARLY_START (EARLY_START)
    ) u_search (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (go),
        .map_i  (map),
        .done_o (done_o),
        .tap_o  (best_tap_o),
        .len_o  (best_len_o),
        .err_o  (err_o)
    );

    // Sweep tap while calibrating, chosen tap once holding
    assign apply_tap = hold ? best_tap_o : sweep_tap;

    rtc_tap_split #(
        .TAP_BITS (TAP_BITS)
    ) u_split (
        .tap_i (apply_tap),
        .s1_o  (stage1_dly_o),
        .s2_o  (stage2_dly_o)
    );

    assign stage2_en_o = full_q;

    // R2: the second stage is only used once the first is saturated
    p_split_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stage2_dly_o != '0) |-> (stage1_dly_o == '1));

    // R3: the enable only turns on through a full-mode start
    p_en_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stage2_en_o) |-> $past(start_i && full_mode_i));
endmodule

// File: tb/sim_rx_tap_calib.sv
// Self-checking bench: directed maps, hole sweeps and pseudo-random maps,
// with results compared against an independent software walk.
module sim_rx_tap_calib;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       full = 1'b0;
    logic       ack = 1'b0;
    logic       pass = 1'b0;
    logic       req, s2en, done, err;
    logic [4:0] s1, s2;
    logic [5:0] tap;
    logic [6:0] len;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_tap_calib #(.SETTLE_CYCLES(SETTLE)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .full_mode_i(full),
        .xfer_req_o(req), .xfer_ack_i(ack), .xfer_pass_i(pass),
        .stage1_dly_o(s1), .stage2_dly_o(s2), .stage2_en_o(s2en),
        .done_o(done), .best_tap_o(tap), .best_len_o(len), .err_o(err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Reference walk: {err, len[6:0], tap[5:0]}
    function automatic logic [13:0] ref_pick(input logic [63:0] m);
        int st = 0;
        int ln;
        int bs = 0;
        int bl = 0;
        int t;
        while (st < 64) begin
            ln = 0;
            while (st + ln < 64 && m[st + ln]) ln++;
            if (bl < ln) begin bs = st; bl = ln; end
            st += (ln != 0) ? ln : 1;
            if (m[63:32] == 32'd0 && ln >= 12 && bs < 4) break;
        end
        t = (bs == 0) ? bl / 3 : (bs + bl / 2) % 64;
        return {(bl == 0), 7'(bl), 6'(t)};
    endfunction

    function automatic int exp_s1(input int t);
        return (t < 32) ? t : 31;
    endfunction

    function automatic int exp_s2(input int t);
        return (t < 32) ? 0 : t - 32;
    endfunction

    // One full calibration; returns nothing, checks everything along the way
    task automatic run_one(input logic [63:0] m_in, input logic fm, input bit poke);
        int steps = fm ? 64 : 32;
        logic [63:0] m = fm ? m_in : {32'd0, m_in[31:0]};
        logic [13:0] e = ref_pick(m);
        int lows;
        int wait_n;
        bit seen;
        @(negedge clk); start = 1'b1; full = fm;
        @(negedge clk); start = 1'b0;
        for (int s = 0; s < steps; s++) begin
            lows = 0;
            while (!req && lows < 200) begin lows++; @(negedge clk); end
            // R4: settle spacing before each request
            chk(lows == SETTLE, "R4 settle gap", lows, SETTLE);
            // R2 / R1: tap k applied on request k
            chk(s1 == 5'(exp_s1(s)) && s2 == 5'(exp_s2(s)), "R2 split during sweep",
                int'({s2, s1}), int'({5'(exp_s2(s)), 5'(exp_s1(s))}));
            chk(s2en == fm, "R3 enable follows mode", s2en, fm);
            if (poke && s == 5) begin
                start = 1'b1;              // R10: must be ignored
                @(negedge clk); start = 1'b0;
            end
            for (int d = 0; d < s % 3; d++) begin
                @(negedge clk);
                chk(req == 1'b1 && s1 == 5'(exp_s1(s)), "R4 request held", req, 1);
            end
            ack = 1'b1; pass = m[s];
            @(negedge clk); ack = 1'b0; pass = 1'b0;
        end
        seen = 1'b0;
        wait_n = 0;
        while (!done && wait_n < 200) begin
            if (req) chk(1'b0, "R1 extra request", 1, 0);
            wait_n++;
            @(negedge clk);
        end
        seen = done;
        chk(seen, "R9 done seen", seen, 1);
        chk(tap == e[5:0], "R7 chosen tap", tap, e[5:0]);
        chk(len == e[12:6], "R5 run length", len, e[12:6]);
        chk(err == e[13], "R8 error flag", err, e[13]);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", done, 0);
        for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            chk(s1 == 5'(exp_s1(e[5:0])) && s2 == 5'(exp_s2(e[5:0])), "R9 chosen tap applied",
                int'({s2, s1}), int'({5'(exp_s2(e[5:0])), 5'(exp_s1(e[5:0]))}));
        end
        chk(req == 1'b0, "R1 no request while holding", req, 0);
    endtask

    // Watchdog: a hang is a failed check
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] lf = 64'h9E37_79B9_7F4A_7C15;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(req == 0 && done == 0, "R11 req/done after reset", int'({req, done}), 0);
        chk(s1 == 0 && s2 == 0, "R11 stages after reset", int'({s2, s1}), 0);
        chk(s2en == 0, "R11 R3 enable after reset", s2en, 0);
        chk(tap == 0 && len == 0 && err == 0, "R11 results after reset", int'({err, len, tap}), 0);

        // R5 full-cycle map: run 18..63 -> tap 41, len 46
        run_one(64'hFFFF_FFFF_FFFC_07FF, 1'b1, 1'b0);
        chk(tap == 6'd41 && len == 7'd46, "R5 full map explicit", tap, 41);
        // R7 low bias: run at 0 of length 11 -> tap 3
        run_one(64'h0000_0000_FFC0_07FF, 1'b0, 1'b0);
        chk(tap == 6'd3 && len == 7'd11, "R7 low bias explicit", tap, 3);
        // R6 early exit in half mode -> tap 4, len 12
        run_one(64'h0000_0000_FFFF_CFFF, 1'b0, 1'b0);
        chk(tap == 6'd4 && len == 7'd12, "R6 early exit half", tap, 4);
        // R6 full mode with empty upper half still exits early
        run_one(64'h0000_0000_FFFF_CFFF, 1'b1, 1'b0);
        chk(tap == 6'd4 && len == 7'd12, "R6 early exit full empty upper", tap, 4);
        // R6 upper bit set disables early exit -> run 14..31 -> tap 23
        run_one(64'h0000_0100_FFFF_CFFF, 1'b1, 1'b0);
        chk(tap == 6'd23 && len == 7'd18, "R6 early exit disabled", tap, 23);
        // R5 tie: lowest equal run wins -> start 4 len 6 -> tap 7
        run_one(64'h0000_0000_03F0_03F0, 1'b1, 1'b0);
        chk(tap == 6'd7 && len == 7'd6, "R5 tie lowest", tap, 7);
        // R8 all zero in both modes
        run_one(64'd0, 1'b0, 1'b0);
        chk(err == 1'b1 && tap == 0 && len == 0, "R8 zero half", err, 1);
        run_one(64'd0, 1'b1, 1'b0);
        chk(err == 1'b1 && tap == 0 && len == 0, "R8 zero full", err, 1);
        // All ones: 64 -> tap 21; 32 -> tap 10
        run_one(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0);
        chk(tap == 6'd21 && len == 7'd64, "R7 all pass full", tap, 21);
        run_one(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
        chk(tap == 6'd10 && len == 7'd32, "R1 half sweep ignores upper taps", tap, 10);
        // R10: start pulse during the sweep is ignored
        run_one(64'h00FF_F000_0FF0_0F00, 1'b1, 1'b1);

        // Hole sweeps
        for (int h = 0; h < 64; h++) run_one(~(64'd1 << h), 1'b1, 1'b0);
        for (int h = 0; h < 32; h++) run_one(~(64'd1 << h), 1'b0, 1'b0);
        // Pseudo-random maps, widened runs by OR-ing shifted copies
        for (int k = 0; k < 40; k++) begin
            lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
            lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
            run_one(lf | (lf >> 1) | (lf << 2), k[0], 1'b0);
        end

        summary();
        $finish;
    end
endmodule